// File: doc/BRIEF.md
# Arithmetic Status Flag Register

This block works out the six arithmetic status flags for four operations: add, add with carry-in, subtract, and subtract with borrow-in. The operand width can be 8, 16 or 32 bits. The flags are stored in a 32-bit status word. Each flag and control bit sits at a fixed position in that word, and the reserved bits are hard-wired.

The execution logic presents the two operands, the operation and the size. When it pulses the update strobe, the new flags are captured at the next clock edge. The width-masked result is available on a combinational output during the same cycle.

The control bits can be loaded on their own without disturbing the status flags. The whole word can also be loaded at once, for example when restoring a saved context. The status word is always readable with its reserved bits filled in.

Top module: `alu_flag_reg`

## Requirements
- R1: After reset `status_o` reads 0x00000002.
- R2: Bit 1 of `status_o` always reads 1. Bits 3, 5, 15 and 31:22 always read 0, and writes to these bits have no effect.
- R3: `op_i` encodes 0 as add, 1 as add with carry-in, 2 as subtract and 3 as subtract with borrow-in. `size_i` encodes 0 as 8 bits, 1 as 16 bits, and 2 or 3 as 32 bits. Operand bits above the selected width are ignored. `result_o` holds the result at that width, with all higher bits zero.
- R4: The carry flag (bit 0) is set when an addition carries out of the top bit of the selected width, or when a subtraction needs a borrow into it.
- R5: Add with carry-in and subtract with borrow-in use the stored carry flag as an extra input of weight one.
- R6: The parity flag (bit 2) is set when bits 7:0 of the result hold an even number of ones, at every width.
- R7: The adjust flag (bit 4) is the carry or borrow that passes between result bits 3 and 4.
- R8: The zero flag (bit 6) is set when the width-masked result is zero. The sign flag (bit 7) copies the top bit of the selected width.
- R9: The overflow flag (bit 11) is set when the operation overflows as a signed operation at the selected width.
- R10: `upd_i` writes only bits 0, 2, 4, 6, 7 and 11. All control bits keep their values.
- R11: `word_we_i` loads every defined bit from `word_i`. The defined bits are 0, 2, 4, 6 to 14, and 16 to 21. This load overrides `ctl_we_i` and `upd_i` in the same cycle.
- R12: `ctl_we_i` loads the control bits from `word_i`. The control bits are 8 to 10, 12 to 14, and 16 to 21. The status flags are untouched, and `upd_i` in the same cycle still updates them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_i | input | 1 | Capture the arithmetic flags at the next edge |
| op_i | input | 2 | Operation select |
| size_i | input | 2 | Operand width select |
| a_i | input | 32 | First operand (minuend) |
| b_i | input | 32 | Second operand (subtrahend) |
| word_we_i | input | 1 | Load all defined bits from word_i |
| ctl_we_i | input | 1 | Load only the control bits from word_i |
| word_i | input | 32 | Write data for the status word |
| result_o | output | 32 | Width-masked result (combinational) |
| status_o | output | 32 | Packed status word |

## Verification
Several properties are checked on every cycle:
- The reserved bits stay fixed.
- A flag update leaves the control bits stable, and a control write leaves the status flags stable.
- A full write lands exactly on the defined bits.
- The zero and parity flags agree with the result of the previous update.

The numeric correctness of carry, adjust, sign and overflow is not checked that way. It depends on operand patterns at each width and on the stored carry feeding back, so only the bench's vectors can show it. Those vectors cover wrap-around at 8, 16 and 32 bits, signed overflow in both directions, borrow-in chains, and same-cycle write priority.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_SIZE = 3;
  localparam int SEL_W    = $clog2(NUM_SIZE);

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int OF_POS = 11;

  localparam logic [WORD_W-1:0] DEF_MASK  = 32'h003F_7FD5;
  localparam logic [WORD_W-1:0] STAT_MASK = 32'h0000_08D5;
  localparam logic [WORD_W-1:0] CTL_MASK  = DEF_MASK & ~STAT_MASK;
  localparam logic [WORD_W-1:0] ONE_MASK  = 32'h0000_0002;
  localparam logic [WORD_W-1:0] ZERO_MASK = ~(DEF_MASK | ONE_MASK);

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_ADC = 2'd1,
    OP_SUB = 2'd2,
    OP_SBB = 2'd3
  } op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  function automatic logic [WORD_W-1:0] pack_flags(flags_t f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CF_POS] = f.cf;
    w[PF_POS] = f.pf;
    w[AF_POS] = f.af;
    w[ZF_POS] = f.zf;
    w[SF_POS] = f.sf;
    w[OF_POS] = f.of;
    return w;
  endfunction
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flag_pkg::*;
(
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              cf_i,
  output logic [WORD_W-1:0] res_o,
  output flags_t            flags_o
);
  logic              is_sub;
  logic              cin;
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] res_v [NUM_SIZE];
  flags_t            fl_v  [NUM_SIZE];

  assign is_sub = op_i[1];
  assign cin    = op_i[0] & cf_i;
  assign sel    = (size_i == 2'd3) ? SEL_W'(2) : SEL_W'(size_i);

  for (genvar gi = 0; gi < NUM_SIZE; gi++) begin : g_size
    localparam int W = 8 << gi;
    logic [W:0]   ext;
    logic [W-1:0] xr;

    always_comb begin
      if (is_sub) ext = {1'b0, a_i[W-1:0]} - {1'b0, b_i[W-1:0]} - {{W{1'b0}}, cin};
      else        ext = {1'b0, a_i[W-1:0]} + {1'b0, b_i[W-1:0]} + {{W{1'b0}}, cin};
    end

    // xr bit k is the carry/borrow that entered bit k
    assign xr = a_i[W-1:0] ^ b_i[W-1:0] ^ ext[W-1:0];

    assign res_v[gi]   = WORD_W'(ext[W-1:0]);
    assign fl_v[gi].cf = ext[W];
    assign fl_v[gi].pf = ~^ext[7:0];
    assign fl_v[gi].af = xr[4];
    assign fl_v[gi].zf = ~|ext[W-1:0];
    assign fl_v[gi].sf = ext[W-1];
    assign fl_v[gi].of = xr[W-1] ^ ext[W];
  end

  assign res_o   = res_v[sel];
  assign flags_o = fl_v[sel];
endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_we_i,
  input  logic              ctl_we_i,
  input  logic              upd_i,
  input  logic [WORD_W-1:0] word_i,
  input  flags_t            flags_i,
  output logic [WORD_W-1:0] status_o
);
  logic [WORD_W-1:0] q, q_n;

  always_comb begin
    q_n = q;
    if (word_we_i) begin
      q_n = word_i & DEF_MASK;
    end else begin
      if (ctl_we_i) q_n = (q_n & ~CTL_MASK) | (word_i & CTL_MASK);
      if (upd_i)    q_n = (q_n & ~STAT_MASK) | pack_flags(flags_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= q_n;
  end

  assign status_o = (q & DEF_MASK) | ONE_MASK;

  AST_RSVD_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] && ((status_o & ZERO_MASK) == '0)); // R2
  AST_WORD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_we_i |=> status_o == (($past(word_i) & DEF_MASK) | ONE_MASK)); // R11
  AST_UPD_KEEPS_CTL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ctl_we_i && !word_we_i) |=>
      ((status_o & CTL_MASK) == ($past(status_o) & CTL_MASK))); // R10
  AST_CTL_KEEPS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !upd_i && !word_we_i) |=>
      ((status_o & STAT_MASK) == ($past(status_o) & STAT_MASK))); // R12
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              word_we_i,
  input  logic              ctl_we_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] result_o,
  output logic [WORD_W-1:0] status_o
);
  flags_t flags;

  flag_calc u_calc (
    .op_i    (op_i),
    .size_i  (size_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .cf_i    (status_o[CF_POS]),
    .res_o   (result_o),
    .flags_o (flags)
  );

  flag_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_we_i (word_we_i),
    .ctl_we_i  (ctl_we_i),
    .upd_i     (upd_i),
    .word_i    (word_i),
    .flags_i   (flags),
    .status_o  (status_o)
  );

  AST_ZF_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !word_we_i) |=> status_o[ZF_POS] == ($past(result_o) == '0)); // R8
  AST_PF_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !word_we_i) |=> status_o[PF_POS] == ~^($past(result_o[7:0]))); // R6
  AST_RES_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd0) |-> (result_o[WORD_W-1:8] == '0)); // R3
  AST_RES_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd1) |-> (result_o[WORD_W-1:16] == '0)); // R3
endmodule

// File: tb/alu_flag_reg_tb.sv
module alu_flag_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam int MAX_CYC = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0, word_we = 1'b0, ctl_we = 1'b0;
  logic [1:0]  op = '0, size = '0;
  logic [31:0] a = '0, b = '0, word = '0;
  logic [31:0] result, status;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .op_i(op), .size_i(size),
    .a_i(a), .b_i(b), .word_we_i(word_we), .ctl_we_i(ctl_we), .word_i(word),
    .result_o(result), .status_o(status)
  );

  // {op, size, a, b, carry_in, result, {of,sf,zf,af,pf,cf}}
  localparam logic [106:0] VECS [NV] = '{
    {2'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, 32'h0000_0000, 6'b001111},
    {2'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 1'b0, 32'h0000_0080, 6'b110100},
    {2'd2, 2'd0, 32'h0000_0000, 32'h0000_0001, 1'b0, 32'h0000_00FF, 6'b010111},
    {2'd2, 2'd0, 32'h0000_0080, 32'h0000_0001, 1'b0, 32'h0000_007F, 6'b100100},
    {2'd0, 2'd1, 32'h1234_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 6'b001111},
    {2'd1, 2'd1, 32'h0000_7FFF, 32'h0000_0000, 1'b1, 32'h0000_8000, 6'b110110},
    {2'd3, 2'd2, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 6'b010111},
    {2'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 6'b101011},
    {2'd1, 2'd0, 32'h0000_0001, 32'h0000_0002, 1'b0, 32'h0000_0003, 6'b000010},
    {2'd2, 2'd1, 32'h0000_1000, 32'h0000_0001, 1'b0, 32'h0000_0FFF, 6'b000110},
    {2'd3, 2'd0, 32'h0000_0010, 32'h0000_000F, 1'b1, 32'h0000_0000, 6'b001110},
    {2'd0, 2'd3, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 32'h0001_0000, 6'b000110}
  };

  function automatic logic [31:0] flag_word(logic [5:0] f);
    logic [31:0] w;
    w = 32'h2;
    w[0] = f[0]; w[2] = f[1]; w[4] = f[2]; w[6] = f[3]; w[7] = f[4]; w[11] = f[5];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic arith(logic [1:0] o, logic [1:0] s, logic [31:0] x, logic [31:0] y);
    op = o; size = s; a = x; b = y; upd = 1'b1;
  endtask

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc >= MAX_CYC);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset value", status, 32'h0000_0002);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6 R7 R8 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      word_we = 1'b1; word = {31'd0, VECS[i][38]};
      @(negedge clk);
      word_we = 1'b0;
      arith(VECS[i][106:105], VECS[i][104:103], VECS[i][102:71], VECS[i][70:39]);
      #1;
      check("R3 result", result, VECS[i][37:6]);
      @(negedge clk);
      upd = 1'b0;
      check("R4-flags vector", status, flag_word(VECS[i][5:0]));
    end

    // R2 R11: full write of all ones
    word_we = 1'b1; word = 32'hFFFF_FFFF;
    @(negedge clk);
    word_we = 1'b0;
    check("R2 reserved bits after write", status, 32'h003F_7FD7);

    // R10: update keeps control bits
    arith(2'd0, 2'd0, 32'h1, 32'h1);
    @(negedge clk);
    upd = 1'b0;
    check("R10 control bits kept", status, 32'h003F_7702);

    // R12: control write keeps status flags
    word_we = 1'b1; word = 32'h0000_08D5;
    @(negedge clk);
    word_we = 1'b0; ctl_we = 1'b1; word = 32'hFFFF_FFFF;
    @(negedge clk);
    ctl_we = 1'b0;
    check("R12 flags kept on control write", status, 32'h003F_7FD7);

    // R12: control write together with update
    ctl_we = 1'b1; word = 32'h0;
    arith(2'd0, 2'd0, 32'h0, 32'h0);
    @(negedge clk);
    ctl_we = 1'b0; upd = 1'b0;
    check("R12 control write with update", status, 32'h0000_0046);

    // R11: full write overrides update
    word_we = 1'b1; word = 32'h0000_0001;
    arith(2'd0, 2'd0, 32'h0, 32'h0);
    @(negedge clk);
    word_we = 1'b0; upd = 1'b0;
    check("R11 write priority", status, 32'h0000_0003);

    // R5: stored carry feeds add-with-carry
    op = 2'd1; size = 2'd0; a = 32'h0; b = 32'h0;
    #1;
    check("R5 stored carry used", result, 32'h0000_0001);
    op = 2'd0;
    #1;
    check("R5 plain add ignores carry", result, 32'h0000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule